// File: doc/BRIEF.md
# Mark and Retransmit Read Controller

This block sits beside a FIFO's read pointer. It lets a stretch of words that has already been read be read again as often as needed. On a read-clock rising edge where `mark` is high, and replay mode is not yet active, the controller records the address of the word now shown on the output register. It then enters replay mode. That address is taken as `rd_ptr - 1` (modulo the pointer range), because the output register always holds the word fetched from the slot just behind the read pointer.

While replay mode is active, a low `rt_n` tells the pointer logic to reload the read pointer from the stored address on every rising edge. The block also stalls the writer once the write pointer reaches the stored address, so data waiting to be replayed is not overwritten. During and after the retransmit pulse it overrides the empty flag or the output-ready flag, depending on the flag mode latched elsewhere. Replay mode ends when `mark` is sampled low on a falling edge of the read clock.

All pins are plain control and status levels. No data moves through the block, so it has no valid/ready channel and applies no back-pressure of its own. The only throttle it exerts is `wr_hold`.

Top module: `mrt_ctl`

## Requirements
- R1: A rising `rclk` edge with `mark` high, while replay mode is inactive, stores `rd_ptr - 1` (wrapping at the pointer width) as the mark. Replay mode becomes active at the following falling edge. The stored address is driven on `rd_load_addr`.
- R2: While replay mode is active, `wr_hold` is 1 exactly when `wr_ptr` equals the stored mark. Outside replay mode `wr_hold` is 0.
- R3: While replay mode is active and `rt_n` is 0, `rd_load` is 1 with `rd_load_addr` equal to the mark. This holds on every cycle that `rt_n` stays low, for any number of cycles.
- R4: With `fwft_mode` = 0 (standard), `ef_hold_low` is 1 from the first rising edge that samples a valid retransmit. It returns to 0 on the first rising edge that samples `rt_n` high again. No preload request follows.
- R5: With `fwft_mode` = 1 (fall-through), `ordy_hold_high` follows the same window as R4. On the releasing edge, `preload_req` is raised for exactly one cycle so the marked word is loaded into the output register.
- R6: A falling `rclk` edge that samples `mark` low ends replay mode. `wr_hold` and `rd_load` then stay 0.
- R7: A new mark taken after replay mode has ended replaces the previous one. Only the latest address is reloaded.
- R8: Repeated retransmits within one replay period all reload the same marked address.
- R9: `rt_n` low has no effect while replay mode is inactive, including on the very edge that takes the mark. No reload, no flag override.
- R10: Either `mrst_n` or `prst_n` low asynchronously ends replay mode, clears the stored mark to 0 and drops every override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, asynchronous, active low |
| mark | input | 1 | Request to record a mark and hold replay mode |
| rt_n | input | 1 | Retransmit request, active low |
| fwft_mode | input | 1 | Latched flag mode: 0 standard, 1 fall-through |
| rd_ptr | input | ADDR_W | Current read pointer |
| wr_ptr | input | ADDR_W | Current write pointer |
| rd_load | output | 1 | Reload the read pointer at this edge |
| rd_load_addr | output | ADDR_W | Stored mark address |
| wr_hold | output | 1 | Stall the write pointer |
| ef_hold_low | output | 1 | Force the empty flag to its empty level (standard mode) |
| ordy_hold_high | output | 1 | Force the output-ready flag to not-ready (fall-through mode) |
| preload_req | output | 1 | One-cycle request to load the marked word into the output register |

## Verification
Taking a mark and requesting a retransmit can land on the same rising edge. The bench provokes this by lowering `rt_n` in the same cycle that `mark` first goes high. It judges the outcome by confirming that no reload and no flag override appear at that edge. It then confirms that the still-low `rt_n` is honoured on the next edge, once replay mode is active. The address sweep also has each new mark follow directly on the exit of the previous one, which shows that the newer address wins.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic [1:0] {
    OV_IDLE    = 2'd0,
    OV_HOLD    = 2'd1,
    OV_PRELOAD = 2'd2
  } ovr_state_e;
endpackage

// File: rtl/mrt_mode_ctl.sv
module mrt_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mark,
  output logic capture,
  output logic rt_mode
);
  logic armed_q;
  logic mark_lo_q;

  // a mark is only taken when replay mode is not already running
  assign capture = mark & ~rt_mode;
  assign rt_mode = armed_q & ~mark_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (capture) begin
      armed_q <= 1'b1;
    end else if (mark_lo_q && !mark) begin
      armed_q <= 1'b0;
    end
  end

  // exit is decided on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_lo_q <= 1'b1;
    end else begin
      mark_lo_q <= ~mark;
    end
  end
endmodule

// File: rtl/mrt_mark_reg.sv
module mrt_mark_reg #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] mark_addr
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_addr <= '0;
    end else if (capture) begin
      mark_addr <= rd_ptr - ONE;
    end
  end
endmodule

// File: rtl/mrt_flag_ovr.sv
module mrt_flag_ovr
  import mrt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rt_mode,
  input  logic rt_n,
  input  logic fwft_mode,
  output logic ef_hold_low,
  output logic ordy_hold_high,
  output logic preload_req
);
  ovr_state_e state_q;
  ovr_state_e state_d;
  logic       rt_valid;

  assign rt_valid = rt_mode & ~rt_n;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OV_IDLE:    if (rt_valid) state_d = OV_HOLD;
      OV_HOLD:    if (rt_n) state_d = fwft_mode ? OV_PRELOAD : OV_IDLE;
      OV_PRELOAD: state_d = rt_valid ? OV_HOLD : OV_IDLE;
      default:    state_d = OV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OV_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign ef_hold_low    = (state_q == OV_HOLD) & ~fwft_mode;
  assign ordy_hold_high = (state_q == OV_HOLD) &  fwft_mode;
  assign preload_req    = (state_q == OV_PRELOAD);
endmodule

// File: rtl/mrt_ctl.sv
module mrt_ctl #(
  parameter int ADDR_W = 10
) (
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              mark,
  input  logic              rt_n,
  input  logic              fwft_mode,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic [ADDR_W-1:0] wr_ptr,
  output logic              rd_load,
  output logic [ADDR_W-1:0] rd_load_addr,
  output logic              wr_hold,
  output logic              ef_hold_low,
  output logic              ordy_hold_high,
  output logic              preload_req
);
  logic rst_all_n;
  logic capture;
  logic rt_mode;

  assign rst_all_n = mrst_n & prst_n;

  mrt_mode_ctl u_mode (
    .clk     (rclk),
    .rst_n   (rst_all_n),
    .mark    (mark),
    .capture (capture),
    .rt_mode (rt_mode)
  );

  mrt_mark_reg #(.ADDR_W(ADDR_W)) u_mark (
    .clk       (rclk),
    .rst_n     (rst_all_n),
    .capture   (capture),
    .rd_ptr    (rd_ptr),
    .mark_addr (rd_load_addr)
  );

  mrt_flag_ovr u_ovr (
    .clk            (rclk),
    .rst_n          (rst_all_n),
    .rt_mode        (rt_mode),
    .rt_n           (rt_n),
    .fwft_mode      (fwft_mode),
    .ef_hold_low    (ef_hold_low),
    .ordy_hold_high (ordy_hold_high),
    .preload_req    (preload_req)
  );

  assign rd_load = rt_mode & ~rt_n;
  assign wr_hold = rt_mode & (wr_ptr == rd_load_addr);
endmodule

// File: rtl/mrt_ctl_chk.sv
module mrt_ctl_chk #(
  parameter int ADDR_W = 10
) (
  input logic              rclk,
  input logic              mrst_n,
  input logic              prst_n,
  input logic              rt_n,
  input logic              fwft_mode,
  input logic              rt_mode,
  input logic              rd_load,
  input logic [ADDR_W-1:0] rd_load_addr,
  input logic              ef_hold_low,
  input logic              ordy_hold_high,
  input logic              preload_req
);
  logic rst_ok;
  assign rst_ok = mrst_n & prst_n;

  AST_RELOAD_SAME_MARK: assert property (@(posedge rclk) disable iff (!rst_ok)
    rd_load && $past(rd_load) |-> $stable(rd_load_addr)); // R8

  AST_EF_RELEASE: assert property (@(posedge rclk) disable iff (!rst_ok)
    $fell(ef_hold_low) && $stable(fwft_mode) |-> $past(rt_n)); // R4

  AST_PRELOAD_ON_RELEASE: assert property (@(posedge rclk) disable iff (!rst_ok)
    $fell(ordy_hold_high) && $stable(fwft_mode) |-> preload_req); // R5

  AST_PRELOAD_SINGLE: assert property (@(posedge rclk) disable iff (!rst_ok)
    preload_req |=> !preload_req); // R5

  AST_OVR_NEEDS_MODE: assert property (@(posedge rclk) disable iff (!rst_ok)
    $rose(ef_hold_low || ordy_hold_high) |-> $past(rt_mode) && !$past(rt_n)); // R9
endmodule

bind mrt_ctl mrt_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .rclk           (rclk),
  .mrst_n         (mrst_n),
  .prst_n         (prst_n),
  .rt_n           (rt_n),
  .fwft_mode      (fwft_mode),
  .rt_mode        (rt_mode),
  .rd_load        (rd_load),
  .rd_load_addr   (rd_load_addr),
  .ef_hold_low    (ef_hold_low),
  .ordy_hold_high (ordy_hold_high),
  .preload_req    (preload_req)
);

// File: tb/mrt_ctl_tb.sv
module mrt_ctl_tb;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          mrst_n, prst_n, mark, rt_n, fwft_mode;
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          rd_load, wr_hold, ef_hold_low, ordy_hold_high, preload_req;
  logic [AW-1:0] rd_load_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mrt_ctl #(.ADDR_W(AW)) u_dut (
    .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mark(mark), .rt_n(rt_n),
    .fwft_mode(fwft_mode), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .rd_load(rd_load), .rd_load_addr(rd_load_addr), .wr_hold(wr_hold),
    .ef_hold_low(ef_hold_low), .ordy_hold_high(ordy_hold_high),
    .preload_req(preload_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // after this, both edges of one cycle have acted on the current inputs
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic flags(input string tag, input int ef, input int ordy, input int pre);
    chk({tag, " ef_hold_low"}, ef_hold_low, ef);
    chk({tag, " ordy_hold_high"}, ordy_hold_high, ordy);
    chk({tag, " preload_req"}, preload_req, pre);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    mrst_n = 1'b0; prst_n = 1'b1; mark = 1'b0; rt_n = 1'b1; fwft_mode = 1'b0;
    rd_ptr = '0; wr_ptr = '0;
    tick(); tick();
    mrst_n = 1'b1;
    #1;
    chk("R10 reset rd_load", rd_load, 0);
    chk("R10 reset wr_hold", wr_hold, 0);
    chk("R10 reset mark", rd_load_addr, 0);
    flags("R10 reset", 0, 0, 0);

    // sweep every mark position, both flag modes
    for (int m = 0; m < N; m++) begin
      int fw;
      int len;
      fw = m % 2;
      len = (m % 3) + 1;
      fwft_mode = fw[0];
      rd_ptr = AW'(m + 1);
      mark = 1'b1;
      tick();
      rd_ptr = AW'(m + 5);
      chk("R1/R7 mark addr", rd_load_addr, m);
      for (int w = 0; w < N; w++) begin
        wr_ptr = AW'(w);
        #1;
        chk("R2 wr_hold", wr_hold, (w == m) ? 1 : 0);
      end
      rt_n = 1'b0;
      for (int i = 0; i < len; i++) begin
        #1;
        chk("R3 rd_load", rd_load, 1);
        chk("R3 reload addr", rd_load_addr, m);
        tick();
        flags(fw ? "R5 hold" : "R4 hold", 1 - fw, fw, 0);
      end
      rt_n = 1'b1;
      #1;
      chk("R3 rd_load release", rd_load, 0);
      tick();
      flags(fw ? "R5 release" : "R4 release", 0, 0, fw);
      tick();
      flags("R5 preload end", 0, 0, 0);
      rt_n = 1'b0;
      #1;
      chk("R8 repeat addr", rd_load_addr, m);
      chk("R8 repeat load", rd_load, 1);
      tick();
      rt_n = 1'b1;
      tick(); tick();
      mark = 1'b0;
      tick();
      rt_n = 1'b0;
      wr_ptr = AW'(m);
      #1;
      chk("R6 rd_load after exit", rd_load, 0);
      chk("R6 wr_hold after exit", wr_hold, 0);
      tick();
      flags("R9 ignored", 0, 0, 0);
      rt_n = 1'b1;
      tick();
    end

    // mark and retransmit on the same edge
    fwft_mode = 1'b1;
    rd_ptr = 4'd7;
    mark = 1'b1;
    rt_n = 1'b0;
    #1;
    chk("R9 same edge rd_load", rd_load, 0);
    tick();
    flags("R9 same edge", 0, 0, 0);
    #1;
    chk("R3 after same edge load", rd_load, 1);
    chk("R1 same edge mark", rd_load_addr, 6);
    tick();
    flags("R5 after same edge", 0, 1, 0);
    rt_n = 1'b1;
    tick();
    flags("R5 after same edge release", 0, 0, 1);
    mark = 1'b0;
    tick(); tick();

    // replacement of one mark by the next
    fwft_mode = 1'b0;
    rd_ptr = 4'd3; mark = 1'b1; tick();
    mark = 1'b0; tick(); tick();
    rd_ptr = 4'd10; mark = 1'b1; tick();
    rt_n = 1'b0;
    #1;
    chk("R7 latest mark", rd_load_addr, 9);
    tick();
    rt_n = 1'b1;
    tick();

    // partial reset mid replay
    rd_ptr = 4'd12;
    tick();
    mark = 1'b0;
    prst_n = 1'b0;
    #1;
    prst_n = 1'b1;
    rt_n = 1'b0;
    wr_ptr = 4'd9;
    #1;
    chk("R10 partial rd_load", rd_load, 0);
    chk("R10 partial wr_hold", wr_hold, 0);
    chk("R10 partial mark", rd_load_addr, 0);
    tick();
    flags("R10 partial", 0, 0, 0);
    rt_n = 1'b1;
    tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule